// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Controller

This block answers cache line-fill requests by reading one aligned block of `N_WORDS` words from a banked main memory. A fill runs in three phases. First, one address cycle sends the block address to the memory. Second, the bank access phase runs. Third, the words return over a shared one-word data path, one word per transfer slot. The memory array is modelled inside the block as latency-only banks. The value of each word is computed from its byte address.

A parameter selects the memory organisation. In the interleaved organisation, word *i* of the block lives in bank *i*, chosen by address bits 3..2. All banks start their access together, so only the word transfers are serialised. In the single-bank organisation, one word-wide bank serves every word. Each word then needs its own full access before its transfer. With the default timing (1-cycle address, 15-cycle access, 1-cycle transfer), a fill lasts 20 cycles in the interleaved organisation and 65 cycles in the single-bank one.

A requester presents an address while the controller is ready and collects the four words as they arrive. A fill-cycle counter on the ports shows where the current fill is in time, so the fill latency can be observed directly.

Top module: `lfill_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `req_ready` is 1, `rsp_valid` is 0 and `fill_cyc` is 0.
- R2: Interleaved organisation. Number the cycle after the accepting edge as cycle 1. The four words then appear in cycles 17, 18, 19 and 20. Those are the only cycles of the fill with `rsp_valid` high.
- R3: Single-bank organisation. The four words appear in cycles 17, 33, 49 and 65 after acceptance. Each is preceded by its own 15-cycle access.
- R4: Word *i* carries `{req_addr[31:4], i[1:0], 2'b00} ^ SALT`. The bench uses `SALT = 32'h3C96_0000`. Request address bits 3..0 have no effect on the data.
- R5: `rsp_idx` equals 0, 1, 2 and 3 on the four words, in that order. `rsp_last` is 1 on the word with index 3 and on no other word.
- R6: `req_ready` is 0 from the accepting edge until the fill ends. A `req_valid` presented during a fill is ignored: it adds no words and changes none of the current fill's data.
- R7: During a fill, `fill_cyc` equals the cycle number since acceptance, so it reads 20 (interleaved) or 65 (single-bank) on the last word. Between fills it holds the last fill's length.
- R8: `req_ready` returns to 1 in the cycle right after the last word. A request held high is then accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request present |
| req_addr | input | ADDR_W | Byte address inside the block to fill |
| req_ready | output | 1 | Controller idle; request taken at the edge when both are high |
| rsp_valid | output | 1 | A fill word is on `rsp_data` |
| rsp_data | output | WORD_W | Returned word |
| rsp_idx | output | log2(N_WORDS) | Position of the word in the block |
| rsp_last | output | 1 | Final word of the block |
| fill_cyc | output | CYC_W | Cycle number within the current or last fill |

## Verification
A phase counter or state that slips by one shifts every later word. Such a fault shows at the ports in the same fill: the last word no longer lands on cycle 20 or 65, and `fill_cyc` disagrees with the cycle on which the word appears. A wrong word index or a stale bank capture shows up on the very next word as a data or index mismatch. A controller stuck busy never raises `req_ready`, which the next request exposes. An accepted stray request appears as an extra word that no expectation covers.

// File: rtl/lfill_pkg.sv
package lfill_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_ACC  = 2'd2,
      FS_XFER = 2'd3
   } fill_st_e;

   // Total bus cycles of one fill, counted from the cycle after acceptance.
   function automatic int fill_len(input bit interleaved, input int n_words,
                                   input int addr_cyc, input int acc_cyc,
                                   input int xfer_cyc);
      if (interleaved)
         return addr_cyc + acc_cyc + n_words * xfer_cyc;
      else
         return addr_cyc + n_words * (acc_cyc + xfer_cyc);
   endfunction

endpackage

// File: rtl/lfill_bank.sv
module lfill_bank #(
   parameter int          WORD_W  = 32,
   parameter int          ADDR_W  = 32,
   parameter int          ACC_CYC = 15,
   parameter logic [31:0] SALT    = 32'h3C96_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic              rdy,
   output logic [WORD_W-1:0] data
);
   localparam int LW = $clog2(ACC_CYC + 1);

   logic [LW-1:0]     left;
   logic              held;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left   <= '0;
         held   <= 1'b0;
         data_q <= '0;
      end else if (start) begin
         left   <= LW'(ACC_CYC);
         held   <= 1'b1;
         data_q <= WORD_W'(addr) ^ WORD_W'(SALT);
      end else if (left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign rdy  = held && (left == '0);
   assign data = data_q;

   // R3: a bank is never restarted while its access is still running
   p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (left == '0));

endmodule

// File: rtl/lfill_seq.sv
module lfill_seq
   import lfill_pkg::*;
#(
   parameter int N_WORDS     = 4,
   parameter int LINE_W      = 28,
   parameter int ADDR_CYC    = 1,
   parameter int ACC_CYC     = 15,
   parameter int XFER_CYC    = 1,
   parameter bit INTERLEAVED = 1'b1,
   parameter int CYC_W       = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [LINE_W-1:0]          req_line,
   output logic                       req_ready,
   output logic                       go,
   output logic [$clog2(N_WORDS)-1:0] go_idx,
   output logic [LINE_W-1:0]          line_q,
   output logic [$clog2(N_WORDS)-1:0] widx,
   output logic                       rsp_valid,
   output logic                       rsp_last,
   output logic [CYC_W-1:0]           fill_cyc
);
   localparam int BSEL_W   = $clog2(N_WORDS);
   localparam int PC_W     = $clog2(ADDR_CYC + ACC_CYC + XFER_CYC + 1);
   localparam int FILL_CYC = fill_len(INTERLEAVED, N_WORDS, ADDR_CYC, ACC_CYC, XFER_CYC);
   localparam bit SINGLE   = !INTERLEAVED;

   fill_st_e         st;
   logic [PC_W-1:0]  pc;
   logic [CYC_W-1:0] cyc;
   logic             last_w;
   logic             slot_end;

   assign last_w   = (widx == BSEL_W'(N_WORDS - 1));
   assign slot_end = (pc == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FS_IDLE;
         pc     <= '0;
         widx   <= '0;
         line_q <= '0;
         cyc    <= '0;
      end else begin
         case (st)
            FS_IDLE: if (req_valid) begin
               st     <= FS_ADDR;
               pc     <= PC_W'(ADDR_CYC - 1);
               widx   <= '0;
               line_q <= req_line;
               cyc    <= CYC_W'(1);
            end
            FS_ADDR: begin
               cyc <= cyc + 1'b1;
               if (slot_end) begin
                  st <= FS_ACC;
                  pc <= PC_W'(ACC_CYC - 1);
               end else pc <= pc - 1'b1;
            end
            FS_ACC: begin
               cyc <= cyc + 1'b1;
               if (slot_end) begin
                  st <= FS_XFER;
                  pc <= PC_W'(XFER_CYC - 1);
               end else pc <= pc - 1'b1;
            end
            FS_XFER: begin
               if (!slot_end) begin
                  pc  <= pc - 1'b1;
                  cyc <= cyc + 1'b1;
               end else if (last_w) begin
                  st <= FS_IDLE;
               end else begin
                  cyc  <= cyc + 1'b1;
                  widx <= widx + 1'b1;
                  if (SINGLE) begin
                     st <= FS_ACC;
                     pc <= PC_W'(ACC_CYC - 1);
                  end else begin
                     pc <= PC_W'(XFER_CYC - 1);
                  end
               end
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

   assign req_ready = (st == FS_IDLE);
   assign rsp_valid = (st == FS_XFER) && slot_end;
   assign rsp_last  = rsp_valid && last_w;
   assign go        = ((st == FS_ADDR) && slot_end) ||
                      (SINGLE && (st == FS_XFER) && slot_end && !last_w);
   assign go_idx    = (st == FS_ADDR) ? '0 : widx + 1'b1;
   assign fill_cyc  = cyc;

   // R6: no word is ever presented while the controller reports idle
   p_busy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   // R7: the last word lands exactly on the nominal fill length
   p_last_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> (fill_cyc == CYC_W'(FILL_CYC)));
   // R7: the fill counter holds while idle and unrequested
   p_cyc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> $stable(fill_cyc));
   // R8: ready comes back right after the final word
   p_ready_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |=> req_ready);

endmodule

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
   import lfill_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          WORD_W      = 32,
   parameter int          N_WORDS     = 4,
   parameter int          ADDR_CYC    = 1,
   parameter int          ACC_CYC     = 15,
   parameter int          XFER_CYC    = 1,
   parameter bit          INTERLEAVED = 1'b1,
   parameter int          CYC_W       = 8,
   parameter logic [31:0] SALT        = 32'h3C96_0000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       req_ready,
   output logic                       rsp_valid,
   output logic [WORD_W-1:0]          rsp_data,
   output logic [$clog2(N_WORDS)-1:0] rsp_idx,
   output logic                       rsp_last,
   output logic [CYC_W-1:0]           fill_cyc
);
   localparam int BSEL_W   = $clog2(N_WORDS);
   localparam int BYTE_W   = $clog2(WORD_W / 8);
   localparam int OFF_W    = BSEL_W + BYTE_W;
   localparam int LINE_W   = ADDR_W - OFF_W;
   localparam int N_BANK   = INTERLEAVED ? N_WORDS : 1;
   localparam int FILL_CYC = fill_len(INTERLEAVED, N_WORDS, ADDR_CYC, ACC_CYC, XFER_CYC);

   if (N_WORDS < 2 || (N_WORDS & (N_WORDS - 1)) != 0) begin : g_bad_words
      $error("N_WORDS must be a power of two, at least 2");
   end
   if (WORD_W < 8 || (WORD_W % 8) != 0 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word_w
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if (ADDR_CYC < 1 || ACC_CYC < 1 || XFER_CYC < 1) begin : g_bad_timing
      $error("every phase needs at least one cycle");
   end
   if (FILL_CYC >= (1 << CYC_W)) begin : g_bad_cyc_w
      $error("CYC_W too narrow for the fill length");
   end
   if (LINE_W < 1) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the block size");
   end

   logic              go;
   logic [BSEL_W-1:0] go_idx;
   logic [LINE_W-1:0] line_q;
   logic [BSEL_W-1:0] widx;
   logic              sel_rdy;
   logic [OFF_W-1:0]  unused_off;
   logic [WORD_W-1:0] bank_data [N_BANK];
   logic              bank_rdy  [N_BANK];

   assign unused_off = req_addr[OFF_W-1:0];

   lfill_seq #(
      .N_WORDS(N_WORDS), .LINE_W(LINE_W), .ADDR_CYC(ADDR_CYC),
      .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC), .INTERLEAVED(INTERLEAVED),
      .CYC_W(CYC_W)
   ) seq_u (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_line(req_addr[ADDR_W-1:OFF_W]), .req_ready(req_ready),
      .go(go), .go_idx(go_idx), .line_q(line_q), .widx(widx),
      .rsp_valid(rsp_valid), .rsp_last(rsp_last), .fill_cyc(fill_cyc)
   );

   if (INTERLEAVED) begin : g_banked
      logic [BSEL_W-1:0] unused_gidx;
      assign unused_gidx = go_idx;
      for (genvar g = 0; g < N_WORDS; g++) begin : g_bank
         lfill_bank #(
            .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .SALT(SALT)
         ) bank_u (
            .clk(clk), .rst_n(rst_n), .start(go),
            .addr({line_q, BSEL_W'(g), {BYTE_W{1'b0}}}),
            .rdy(bank_rdy[g]), .data(bank_data[g])
         );
      end
      assign rsp_data = bank_data[widx];
      assign sel_rdy  = bank_rdy[widx];
   end else begin : g_single
      lfill_bank #(
         .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .SALT(SALT)
      ) bank_u (
         .clk(clk), .rst_n(rst_n), .start(go),
         .addr({line_q, go_idx, {BYTE_W{1'b0}}}),
         .rdy(bank_rdy[0]), .data(bank_data[0])
      );
      assign rsp_data = bank_data[0];
      assign sel_rdy  = bank_rdy[0];
   end

   assign rsp_idx = widx;

   // R2: the sequencer never presents a word before the bank finished its access
   p_bank_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> sel_rdy);

endmodule

// File: tb/lfill_ctrl_tb_top.sv
`timescale 1ns/1ps
module lfill_ctrl_tb_top;
   localparam logic [31:0] SALT  = 32'h3C96_0000;
   localparam int          TOT_I = 20;
   localparam int          TOT_S = 65;

   typedef struct {
      logic [31:0] d;
      logic [1:0]  idx;
      int          cyc;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        vld_i = 1'b0, vld_s = 1'b0;
   logic [31:0] adr_i = '0, adr_s = '0;
   logic        rdy_i, rv_i, rl_i, rdy_s, rv_s, rl_s;
   logic [31:0] rd_i, rd_s;
   logic [1:0]  rx_i, rx_s;
   logic [7:0]  fc_i, fc_s;

   lfill_ctrl #(.INTERLEAVED(1'b1), .SALT(SALT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(vld_i), .req_addr(adr_i),
      .req_ready(rdy_i), .rsp_valid(rv_i), .rsp_data(rd_i), .rsp_idx(rx_i),
      .rsp_last(rl_i), .fill_cyc(fc_i));

   lfill_ctrl #(.INTERLEAVED(1'b0), .SALT(SALT)) dut_s (
      .clk(clk), .rst_n(rst_n), .req_valid(vld_s), .req_addr(adr_s),
      .req_ready(rdy_s), .rsp_valid(rv_s), .rsp_data(rd_s), .rsp_idx(rx_s),
      .rsp_last(rl_s), .fill_cyc(fc_s));

   int   n_chk = 0, n_fail = 0;
   int   cnt_i = 0, cnt_s = 0;
   bit   exp_rdy_i = 0, exp_rdy_s = 0;
   exp_t q_i[$];
   exp_t q_s[$];

   task automatic chk(input bit ok, input string tag, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, what);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Independent cycle-since-acceptance counters
   always @(posedge clk) begin
      if (!rst_n) cnt_i <= 0;
      else if (vld_i && rdy_i) cnt_i <= 1;
      else if (cnt_i == TOT_I) cnt_i <= 0;
      else if (cnt_i != 0) cnt_i <= cnt_i + 1;
   end
   always @(posedge clk) begin
      if (!rst_n) cnt_s <= 0;
      else if (vld_s && rdy_s) cnt_s <= 1;
      else if (cnt_s == TOT_S) cnt_s <= 0;
      else if (cnt_s != 0) cnt_s <= cnt_s + 1;
   end

   // Monitor / scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (exp_rdy_i) chk(rdy_i == 1'b1, "R8", $sformatf("interleaved ready act=%0b exp=1", rdy_i));
         exp_rdy_i = rl_i;
         if (cnt_i != 0) chk(rdy_i == 1'b0, "R6", $sformatf("interleaved ready while busy act=%0b exp=0", rdy_i));
         if (rv_i) begin
            if (q_i.size() == 0) chk(1'b0, "R6", $sformatf("interleaved stray word act=%h exp=none", rd_i));
            else begin
               e = q_i.pop_front();
               chk(rd_i == e.d, "R4", $sformatf("interleaved data act=%h exp=%h", rd_i, e.d));
               chk(rx_i == e.idx, "R5", $sformatf("interleaved idx act=%0d exp=%0d", rx_i, e.idx));
               chk(rl_i == (e.idx == 2'd3), "R5", $sformatf("interleaved last act=%0b exp=%0b", rl_i, e.idx == 2'd3));
               chk(cnt_i == e.cyc, "R2", $sformatf("interleaved word cycle act=%0d exp=%0d", cnt_i, e.cyc));
               chk(int'(fc_i) == cnt_i, "R7", $sformatf("interleaved fill_cyc act=%0d exp=%0d", fc_i, cnt_i));
            end
         end
         if (exp_rdy_s) chk(rdy_s == 1'b1, "R8", $sformatf("single ready act=%0b exp=1", rdy_s));
         exp_rdy_s = rl_s;
         if (cnt_s != 0) chk(rdy_s == 1'b0, "R6", $sformatf("single ready while busy act=%0b exp=0", rdy_s));
         if (rv_s) begin
            if (q_s.size() == 0) chk(1'b0, "R6", $sformatf("single stray word act=%h exp=none", rd_s));
            else begin
               e = q_s.pop_front();
               chk(rd_s == e.d, "R4", $sformatf("single data act=%h exp=%h", rd_s, e.d));
               chk(rx_s == e.idx, "R5", $sformatf("single idx act=%0d exp=%0d", rx_s, e.idx));
               chk(rl_s == (e.idx == 2'd3), "R5", $sformatf("single last act=%0b exp=%0b", rl_s, e.idx == 2'd3));
               chk(cnt_s == e.cyc, "R3", $sformatf("single word cycle act=%0d exp=%0d", cnt_s, e.cyc));
               chk(int'(fc_s) == cnt_s, "R7", $sformatf("single fill_cyc act=%0d exp=%0d", fc_s, cnt_s));
            end
         end
      end
   end

   // Driver: pushes expectations, then presents the request when ready
   task automatic issue(input bit sel, input logic [31:0] a, input bit junk);
      for (int k = 0; k < 4; k++) begin
         exp_t e;
         e.d   = {a[31:4], 2'(k), 2'b00} ^ SALT;
         e.idx = 2'(k);
         e.cyc = sel ? 17 + 16 * k : 17 + k;
         if (sel) q_s.push_back(e); else q_i.push_back(e);
      end
      while (!(sel ? rdy_s : rdy_i)) @(negedge clk);
      if (sel) begin vld_s = 1'b1; adr_s = a; end
      else     begin vld_i = 1'b1; adr_i = a; end
      @(negedge clk);
      if (junk) begin
         if (sel) adr_s = ~a; else adr_i = ~a;
         repeat (8) @(negedge clk);
      end
      if (sel) vld_s = 1'b0; else vld_i = 1'b0;
   endtask

   task automatic drain();
      while (q_i.size() != 0 || q_s.size() != 0 || !rdy_i || !rdy_s) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rdy_i == 1'b1 && rdy_s == 1'b1, "R1", $sformatf("ready act=%0b%0b exp=11", rdy_i, rdy_s));
      chk(rv_i == 1'b0 && rv_s == 1'b0, "R1", $sformatf("valid act=%0b%0b exp=00", rv_i, rv_s));
      chk(fc_i == 8'd0 && fc_s == 8'd0, "R1", $sformatf("fill_cyc act=%0d/%0d exp=0", fc_i, fc_s));
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdy_i == 1'b1 && rdy_s == 1'b1, "R1", $sformatf("ready after release act=%0b%0b exp=11", rdy_i, rdy_s));
      chk(fc_i == 8'd0 && fc_s == 8'd0, "R1", $sformatf("fill_cyc after release act=%0d/%0d exp=0", fc_i, fc_s));

      // R2/R3/R4: basic fill with nonzero offset bits
      issue(1'b0, 32'h0000_1234, 1'b0);
      issue(1'b1, 32'h0000_1234, 1'b0);
      drain();
      // R7: length held between fills
      repeat (5) @(negedge clk);
      chk(fc_i == 8'(TOT_I), "R7", $sformatf("interleaved hold act=%0d exp=%0d", fc_i, TOT_I));
      chk(fc_s == 8'(TOT_S), "R7", $sformatf("single hold act=%0d exp=%0d", fc_s, TOT_S));

      // R6: requests during a fill are ignored
      issue(1'b0, 32'hABCD_EF08, 1'b1);
      issue(1'b1, 32'h8000_0FFC, 1'b1);
      drain();

      // R8: back-to-back requests, boundary addresses
      issue(1'b0, 32'h0000_0040, 1'b0);
      issue(1'b0, 32'hFFFF_FFFF, 1'b0);
      issue(1'b0, 32'h0000_0000, 1'b0);
      drain();
      issue(1'b1, 32'hFFFF_FFF3, 1'b0);
      issue(1'b1, 32'h1357_9BD0, 1'b0);
      drain();
      chk(q_i.size() == 0 && q_s.size() == 0, "R5",
          $sformatf("words missing act=%0d/%0d exp=0", q_i.size(), q_s.size()));
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      report();
   end
endmodule